// File: doc/BRIEF.md
# Lockable Victim Way Picker

This block chooses which way of a set-associative instruction cache receives a new line when a fetch misses. Ways are grouped in adjacent pairs, and one configuration bit per pair keeps both ways out of every allocation. If every pair is protected, the cache stops filling and the picker reports that no allocation is allowed.

Inside the set, an invalid unprotected way always wins, lowest index first. If no such way exists, a per-set rotating pointer names where the search for the next unprotected way starts. The pointer moves only when the cache controller reports that a fill has completed. The picker also tells the controller what to do with the line it displaces. A modified line is always written out. A clean line is either written out or silently dropped, depending on an eviction-enable setting. Writing clean lines out is meant for a downstream cache that holds only victims.

The response is registered. Tag storage, data arrays and the victim transfer are handled outside the block.

Top module: `cache_victim_sel`

## Requirements
- R1: Configuration bit k of the lock mask protects ways 2k and 2k+1. A protected way is never reported as the victim while rsp_alloc_ok is 1.
- R2: When all lock bits are 1, a response has rsp_alloc_ok = 0 and rsp_disp = 0 (nothing to do).
- R3: After reset, the lock mask is all zeros and eviction-enable is 0. Every set's pointer starts at way 0.
- R4: If any unprotected way is invalid, the lowest-indexed one is chosen, with rsp_disp = 0 (nothing to do).
- R5: If every unprotected way is valid, the search starts at the requested set's pointer, rises through the way indices and wraps past the top. The first unprotected way it meets is chosen.
- R6: A pulse of fill_done sets the pointer of fill_set to fill_way + 1, wrapping to 0 after the top way. Nothing else moves any pointer, and the pointers of other sets are unchanged.
- R7: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1. The other response fields belong to that request.
- R8: A chosen way that is valid and dirty gives rsp_disp = 2 (write out), whatever the eviction-enable setting.
- R9: A chosen way that is valid and clean gives rsp_disp = 1 (drop) when eviction-enable is 0, and rsp_disp = 2 (write out) when it is 1.
- R10: The lock mask and eviction-enable take the cfg_lock_in and cfg_evict_in values only on a cycle with cfg_we = 1. Otherwise they keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the configuration |
| cfg_lock_in | input | LOCK_W (8) | New lock mask, one bit per way pair |
| cfg_evict_in | input | 1 | New eviction-enable value |
| req_valid | input | 1 | Miss-allocate request |
| req_set | input | SET_W (6) | Set index of the miss |
| way_valid | input | NUM_WAYS (16) | Valid bits of the addressed set |
| way_dirty | input | NUM_WAYS (16) | Dirty bits of the addressed set |
| fill_done | input | 1 | An allocation has completed |
| fill_set | input | SET_W (6) | Set of the completed allocation |
| fill_way | input | WAY_W (4) | Way of the completed allocation |
| rsp_valid | output | 1 | The response fields are valid |
| rsp_alloc_ok | output | 1 | Allocation is allowed |
| rsp_way | output | WAY_W (4) | Chosen way |
| rsp_disp | output | 2 | 0 nothing to do, 1 drop, 2 write out |

## Verification
The bench builds the block with its defaults: 16 ways in 8 lockable pairs and 64 sets. This lets it sweep every single pair left unprotected, and drive the pointer through its wrap from way 15 back to way 0. The bench also drives the pointer onto a protected pair, so the search has to skip forward. With 64 sets, the bench can show that two sets keep separate pointers and that a fill in one set leaves the other alone.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_DROP  = 2'd1,
    DISP_WRITE = 2'd2
  } disp_e;
endpackage

// File: rtl/cvs_cfg_reg.sv
module cvs_cfg_reg #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LOCK_W-1:0] lock_in,
  input  logic              evict_in,
  output logic [LOCK_W-1:0] lock_q,
  output logic              evict_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= '0;
      evict_q <= 1'b0;
    end else if (we) begin
      lock_q  <= lock_in;
      evict_q <= evict_in;
    end
  end
endmodule

// File: rtl/cvs_lock_expand.sv
module cvs_lock_expand #(
  parameter int NUM_WAYS      = 16,
  parameter int WAYS_PER_LOCK = 2,
  localparam int LOCK_W       = NUM_WAYS / WAYS_PER_LOCK
) (
  input  logic [LOCK_W-1:0]   lock,
  output logic [NUM_WAYS-1:0] way_locked
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_locked[w] = lock[w / WAYS_PER_LOCK];
  end
endmodule

// File: rtl/cvs_rr_ptr.sv
module cvs_rr_ptr #(
  parameter int NUM_WAYS = 16,
  parameter int NUM_SETS = 64,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_ptr,
  input  logic             upd,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way
);
  logic [WAY_W-1:0] ptr_mem [NUM_SETS];

  function automatic logic [WAY_W-1:0] next_way(input logic [WAY_W-1:0] w);
    return (w == WAY_W'(NUM_WAYS - 1)) ? '0 : w + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ptr_mem[s] <= '0;
    end else if (upd) begin
      ptr_mem[upd_set] <= next_way(upd_way);
    end
  end

  assign rd_ptr = ptr_mem[rd_set];
endmodule

// File: rtl/cvs_pick.sv
module cvs_pick #(
  parameter int NUM_WAYS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] way_locked,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic [WAY_W-1:0]    ptr,
  output logic                any_open,
  output logic [WAY_W-1:0]    pick
);
  logic [NUM_WAYS-1:0] open_ways;
  logic [NUM_WAYS-1:0] free_ways;
  logic [WAY_W-1:0]    free_pick;
  logic [WAY_W-1:0]    rr_pick;

  function automatic logic [WAY_W-1:0] lowest_set(input logic [NUM_WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] rotate_pick(input logic [NUM_WAYS-1:0] v,
                                                   input logic [WAY_W-1:0]    start);
    logic [WAY_W-1:0] r;
    logic [WAY_W-1:0] idx;
    logic             hit;
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      idx = WAY_W'((int'(start) + i) % NUM_WAYS);
      if (!hit && v[idx]) begin
        r   = idx;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign open_ways = ~way_locked;
  assign free_ways = open_ways & ~way_valid;
  assign any_open  = |open_ways;
  assign free_pick = lowest_set(free_ways);
  assign rr_pick   = rotate_pick(open_ways, ptr);
  assign pick      = (|free_ways) ? free_pick : rr_pick;
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int NUM_WAYS      = 16,
  parameter int WAYS_PER_LOCK = 2,
  parameter int NUM_SETS      = 64,
  localparam int LOCK_W       = NUM_WAYS / WAYS_PER_LOCK,
  localparam int WAY_W        = $clog2(NUM_WAYS),
  localparam int SET_W        = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [LOCK_W-1:0]   cfg_lock_in,
  input  logic                cfg_evict_in,
  input  logic                req_valid,
  input  logic [SET_W-1:0]    req_set,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic [NUM_WAYS-1:0] way_dirty,
  input  logic                fill_done,
  input  logic [SET_W-1:0]    fill_set,
  input  logic [WAY_W-1:0]    fill_way,
  output logic                rsp_valid,
  output logic                rsp_alloc_ok,
  output logic [WAY_W-1:0]    rsp_way,
  output logic [1:0]          rsp_disp
);
  import cvs_pkg::*;

  logic [LOCK_W-1:0]   lock_q;
  logic                evict_q;
  logic [NUM_WAYS-1:0] way_locked;
  logic [WAY_W-1:0]    set_ptr;
  logic                any_open;
  logic [WAY_W-1:0]    pick_way;
  disp_e               pick_disp;

  cvs_cfg_reg #(.LOCK_W(LOCK_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .lock_in(cfg_lock_in),
    .evict_in(cfg_evict_in), .lock_q(lock_q), .evict_q(evict_q)
  );

  cvs_lock_expand #(.NUM_WAYS(NUM_WAYS), .WAYS_PER_LOCK(WAYS_PER_LOCK)) u_exp (
    .lock(lock_q), .way_locked(way_locked)
  );

  cvs_rr_ptr #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rd_set(req_set), .rd_ptr(set_ptr),
    .upd(fill_done), .upd_set(fill_set), .upd_way(fill_way)
  );

  cvs_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .way_locked(way_locked), .way_valid(way_valid), .ptr(set_ptr),
    .any_open(any_open), .pick(pick_way)
  );

  function automatic disp_e disposition(input logic ok, input logic vld,
                                        input logic dty, input logic evict);
    if (!ok || !vld) return DISP_NONE;
    if (dty || evict) return DISP_WRITE;
    return DISP_DROP;
  endfunction

  assign pick_disp = disposition(any_open, way_valid[pick_way],
                                 way_dirty[pick_way], evict_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_alloc_ok <= 1'b0;
      rsp_way      <= '0;
      rsp_disp     <= DISP_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_alloc_ok <= any_open;
        rsp_way      <= any_open ? pick_way : '0;
        rsp_disp     <= pick_disp;
      end
    end
  end
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
  parameter int NUM_WAYS      = 16,
  parameter int WAYS_PER_LOCK = 2,
  localparam int LOCK_W       = NUM_WAYS / WAYS_PER_LOCK,
  localparam int WAY_W        = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [LOCK_W-1:0]   lock_q,
  input logic [NUM_WAYS-1:0] way_valid,
  input logic [NUM_WAYS-1:0] way_dirty,
  input logic                rsp_valid,
  input logic                rsp_alloc_ok,
  input logic [WAY_W-1:0]    rsp_way,
  input logic [1:0]          rsp_disp
);
  logic [LOCK_W-1:0]   lock_d;
  logic [NUM_WAYS-1:0] valid_d;
  logic [NUM_WAYS-1:0] dirty_d;

  always_ff @(posedge clk) begin
    lock_d  <= lock_q;
    valid_d <= way_valid;
    dirty_d <= way_dirty;
  end

  p_locked_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc_ok) |-> !lock_d[int'(rsp_way) / WAYS_PER_LOCK]);

  p_all_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (&lock_d)) |-> (!rsp_alloc_ok && rsp_disp == 2'd0));

  p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !$past(req_valid) && $past(rst_n)) |-> !rsp_valid);

  p_invalid_nothing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc_ok && !valid_d[rsp_way]) |-> rsp_disp == 2'd0);

  p_dirty_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc_ok && valid_d[rsp_way] && dirty_d[rsp_way]) |-> rsp_disp == 2'd2);
endmodule

bind cache_victim_sel cvs_checker #(.NUM_WAYS(NUM_WAYS), .WAYS_PER_LOCK(WAYS_PER_LOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lock_q(lock_q),
  .way_valid(way_valid), .way_dirty(way_dirty), .rsp_valid(rsp_valid),
  .rsp_alloc_ok(rsp_alloc_ok), .rsp_way(rsp_way), .rsp_disp(rsp_disp)
);

// File: tb/tb_cache_victim_sel.sv
`timescale 1ns/1ps
module tb_cache_victim_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_lock_in = '0;
  logic        cfg_evict_in = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_set = '0;
  logic [15:0] way_valid = '0;
  logic [15:0] way_dirty = '0;
  logic        fill_done = 1'b0;
  logic [5:0]  fill_set = '0;
  logic [3:0]  fill_way = '0;
  logic        rsp_valid, rsp_alloc_ok;
  logic [3:0]  rsp_way;
  logic [1:0]  rsp_disp;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cache_victim_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock_in(cfg_lock_in),
    .cfg_evict_in(cfg_evict_in), .req_valid(req_valid), .req_set(req_set),
    .way_valid(way_valid), .way_dirty(way_dirty), .fill_done(fill_done),
    .fill_set(fill_set), .fill_way(fill_way), .rsp_valid(rsp_valid),
    .rsp_alloc_ok(rsp_alloc_ok), .rsp_way(rsp_way), .rsp_disp(rsp_disp)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] lk, input logic ev);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lock_in = lk; cfg_evict_in = ev;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill(input logic [5:0] s, input logic [3:0] w);
    @(negedge clk);
    fill_done = 1'b1; fill_set = s; fill_way = w;
    @(negedge clk);
    fill_done = 1'b0;
  endtask

  task automatic miss(input logic [5:0] s, input logic [15:0] v, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_set = s; way_valid = v; way_dirty = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input int ok, input int way, input int disp);
    check({tag, " valid"}, int'(rsp_valid), 1);
    check({tag, " alloc_ok"}, int'(rsp_alloc_ok), ok);
    if (ok != 0) check({tag, " way"}, int'(rsp_way), way);
    check({tag, " disp"}, int'(rsp_disp), disp);
  endtask

  task automatic t_reset;
    check("R3 rsp_valid in reset", int'(rsp_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    miss(6'd0, 16'hFFFF, 16'h0000);
    expect_rsp("R3 defaults", 1, 0, 1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    check("R7 no request no response", int'(rsp_valid), 0);
  endtask

  task automatic t_invalid_first;
    miss(6'd1, ~16'h0220, 16'h0000);
    expect_rsp("R4 lowest invalid", 1, 5, 0);
    set_cfg(8'h04, 1'b0);
    miss(6'd1, ~16'h0220, 16'h0000);
    expect_rsp("R4 skip locked invalid", 1, 9, 0);
    set_cfg(8'h00, 1'b0);
  endtask

  task automatic t_lock_pairs;
    for (int k = 0; k < 8; k++) begin
      set_cfg(~(8'(1) << k), 1'b0);
      miss(6'd2, 16'h0000, 16'h0000);
      expect_rsp("R1 lone open pair low", 1, 2 * k, 0);
      miss(6'd2, ~(16'(1) << (2 * k + 1)), 16'h0000);
      expect_rsp("R1 lone open pair high", 1, 2 * k + 1, 0);
    end
    set_cfg(8'h01, 1'b0);
    miss(6'd5, ~16'h0003, 16'h0000);
    expect_rsp("R1 locked invalid pair ignored", 1, 2, 1);
    set_cfg(8'h00, 1'b0);
  endtask

  task automatic t_all_locked;
    set_cfg(8'hFF, 1'b1);
    miss(6'd7, 16'h0000, 16'h0000);
    expect_rsp("R2 all locked empty", 0, 0, 0);
    miss(6'd7, 16'hFFFF, 16'hFFFF);
    expect_rsp("R2 all locked full dirty", 0, 0, 0);
    set_cfg(8'h00, 1'b0);
  endtask

  task automatic t_cfg_hold;
    @(negedge clk);
    cfg_lock_in = 8'hFF; cfg_evict_in = 1'b1;
    @(negedge clk);
    cfg_lock_in = 8'h00; cfg_evict_in = 1'b0;
    miss(6'd6, 16'hFFFF, 16'h0000);
    expect_rsp("R10 no write no change", 1, 0, 1);
  endtask

  task automatic t_round_robin;
    miss(6'd3, 16'hFFFF, 16'h0000);
    expect_rsp("R5 pointer starts at 0", 1, 0, 1);
    fill(6'd3, 4'd0);
    miss(6'd3, 16'hFFFF, 16'h0000);
    expect_rsp("R6 advance after fill", 1, 1, 1);
    miss(6'd3, 16'hFFFF, 16'h0000);
    expect_rsp("R6 no advance without fill", 1, 1, 1);
    fill(6'd3, 4'd15);
    miss(6'd3, 16'hFFFF, 16'h0000);
    expect_rsp("R6 wrap after top way", 1, 0, 1);
    fill(6'd3, 4'd7);
    miss(6'd3, 16'hFFFF, 16'h0000);
    expect_rsp("R5 pointer mid", 1, 8, 1);
    miss(6'd4, 16'hFFFF, 16'h0000);
    expect_rsp("R6 other set untouched", 1, 0, 1);
    set_cfg(8'h10, 1'b0);
    miss(6'd3, 16'hFFFF, 16'h0000);
    expect_rsp("R5 pointer on locked pair skips", 1, 10, 1);
    set_cfg(8'h00, 1'b0);
  endtask

  task automatic t_disposition;
    miss(6'd10, 16'hFFFF, 16'h0001);
    expect_rsp("R8 dirty evict off", 1, 0, 2);
    set_cfg(8'h00, 1'b1);
    miss(6'd10, 16'hFFFF, 16'h0001);
    expect_rsp("R8 dirty evict on", 1, 0, 2);
    miss(6'd10, 16'hFFFF, 16'h0000);
    expect_rsp("R9 clean evict on", 1, 0, 2);
    set_cfg(8'h00, 1'b0);
    miss(6'd10, 16'hFFFF, 16'h0000);
    expect_rsp("R9 clean evict off", 1, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_timing();
    t_invalid_first();
    t_lock_pairs();
    t_all_locked();
    t_cfg_hold();
    t_round_robin();
    t_disposition();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule